// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs the external bus cycles of a small microcontroller whose lower address and data share one set of pins. When the core raises a request, the controller issues an address-latch pulse. It then holds the read or write strobe low for a number of states. That number comes from the memory region being accessed, a two-bit wait selection and the data-float option. A ready pin from the memory system can stretch the strobe further. The controller reports the end of each cycle with a single-clock done pulse.

For slow memories that release the shared bus late, an active-low configuration bit enables an extended dead time. After a read, one extra idle state follows before the controller drives the next address. With this option the wait-state choices narrow to one or three states. The fetch of the configuration bytes always runs with the extended timing. A separate enable turns on a free-running wait clock at half the oscillator rate, which external logic can use to time its ready signal. One state of the bus lasts one clock of `clk`.

Top module: `ext_bus_waitctl`

## Requirements
- R1: During and directly after reset, ale=0, rd_n=1, wr_n=1, bus_drive=0, wclk=0 and done=0.
- R2: A request sampled while the controller is idle produces ale=1 for exactly one clock, starting one clock after the sampling edge, and the strobe falls in the clock right after that pulse.
- R3: For region 2'b01 with cfg_float_n=1, the strobe is held low for 1+N clocks, where wait_sel 2'b00, 2'b01, 2'b10 and 2'b11 give N = 3, 2, 1 and 0.
- R4: For region 2'b01 with cfg_float_n=0, wait_sel 2'b11 or 2'b10 gives N=1 and wait_sel 2'b01 or 2'b00 gives N=3.
- R5: Regions 2'b00, 2'b10 and 2'b11 always use N=0.
- R6: A cycle with req_cfg=1 applies the extended-timing wait rule and dead time, whatever the value of cfg_float_n.
- R7: After a read that uses extended timing, the controller spends one extra clock idle with bus_drive=0 and does not accept a request. Writes never add this dead time.
- R8: When wait_pin_en=1, wait_n passes through a two-flop synchronizer. Each strobe clock in which the synchronized value is low adds one strobe clock. When wait_pin_en=0, wait_n has no effect.
- R9: When wclk_en=1, wclk inverts on every clock. When wclk_en=0, wclk is 0.
- R10: done is high for exactly one clock, in the clock after the strobe rises. No new ale is issued before that clock.
- R11: bus_drive is high while ale is high and while the write strobe is low. It is low while the read strobe is low.
- R12: rd_n and wr_n are never low together. The read strobe is used when req_write=0 and the write strobe when req_write=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus cycle request, sampled when idle |
| req_region | input | 2 | Memory region of the requested cycle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cfg | input | 1 | Cycle is a configuration-byte fetch |
| cfg_float_n | input | 1 | Active-low enable of extended data-float timing |
| cfg_wait_sel | input | 2 | Active-low wait-state selection for region 01 |
| wait_pin_en | input | 1 | Honor the external ready pin |
| wclk_en | input | 1 | Enable the wait clock output |
| wait_n | input | 1 | Asynchronous ready pin, low holds off completion |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bus_drive | output | 1 | Controller drives the multiplexed bus |
| wclk | output | 1 | Wait clock at half the clock rate |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
Two events can fall in the same cycle. The first is the last configured wait state running out while the synchronized ready pin is low. The second is the float dead time overlapping a request that is already waiting. The bench holds wait_n low from the request edge for a set number of clocks, so that the synchronized low values cover both the configured wait states and the states after them. It then checks that the strobe length equals one plus the configured waits plus the number of low clocks. It also keeps req high from the done clock onward and measures how many clocks pass before the next ale. The expected gap is two clocks, or three when the extended dead time applies. A reference model running cycle by cycle compares every output on every clock.

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] req_region,
  input  logic       req_write,
  input  logic       req_cfg,
  input  logic       cfg_float_n,
  input  logic [1:0] cfg_wait_sel,
  input  logic       wait_pin_en,
  input  logic       wclk_en,
  input  logic       wait_n,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       bus_drive,
  output logic       wclk,
  output logic       done
);
  localparam logic [1:0] SLOW_REGION = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_END, S_FLT} st_t;

  st_t        st;
  logic [1:0] cnt;
  logic       is_wr, flt_pend, wclk_q;
  logic [1:0] sync;

  logic       ext_tim, stall;
  logic [1:0] waits;

  assign ext_tim = ~cfg_float_n | req_cfg;
  assign waits   = (req_region != SLOW_REGION) ? 2'd0 :
                   ext_tim ? (cfg_wait_sel[1] ? 2'd1 : 2'd3) : ~cfg_wait_sel;
  assign stall   = wait_pin_en & ~sync[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      flt_pend <= 1'b0;
      sync     <= 2'b11;
      wclk_q   <= 1'b0;
    end else begin
      sync   <= {sync[0], wait_n};
      wclk_q <= wclk_en ? ~wclk_q : 1'b0;
      case (st)
        S_IDLE: if (req) begin
          st       <= S_ADDR;
          cnt      <= waits;
          is_wr    <= req_write;
          flt_pend <= ext_tim & ~req_write;
        end
        S_ADDR: st <= S_STRB;
        S_STRB: if (!stall) begin
          if (cnt == 2'd0) st <= S_END;
          else cnt <= cnt - 2'd1;
        end
        S_END:   st <= flt_pend ? S_FLT : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ale       = (st == S_ADDR);
  assign rd_n      = ~((st == S_STRB) & ~is_wr);
  assign wr_n      = ~((st == S_STRB) & is_wr);
  assign bus_drive = ale | ~wr_n;
  assign done      = (st == S_END);
  assign wclk      = wclk_q;
endmodule

// File: rtl/ext_bus_waitctl_chk.sv
module ext_bus_waitctl_chk (
  input logic clk,
  input logic rst_n,
  input logic wclk_en,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_drive,
  input logic wclk,
  input logic done
);
  AST_STROBE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R12
  AST_ALE_ONE:      assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R2
  AST_ALE_STROBE:   assert property (@(posedge clk) disable iff (!rst_n) ale |=> (!rd_n || !wr_n)); // R2
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(!rd_n || !wr_n)); // R10
  AST_DONE_NO_ALE:  assert property (@(posedge clk) disable iff (!rst_n) done |-> !ale); // R10
  AST_ALE_DRIVE:    assert property (@(posedge clk) disable iff (!rst_n) ale |-> bus_drive); // R11
  AST_WR_DRIVE:     assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> bus_drive); // R11
  AST_RD_RELEASE:   assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_drive); // R11
  AST_WCLK_TOGGLE:  assert property (@(posedge clk) disable iff (!rst_n)
                      ($past(rst_n) && $past(wclk_en) && wclk_en) |-> (wclk != $past(wclk))); // R9
endmodule

bind ext_bus_waitctl ext_bus_waitctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wclk_en(wclk_en), .ale(ale), .rd_n(rd_n),
  .wr_n(wr_n), .bus_drive(bus_drive), .wclk(wclk), .done(done)
);

// File: tb/ext_bus_waitctl_tb.sv
module ext_bus_waitctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0, req_cfg = 1'b0;
  logic [1:0] req_region = 2'b00, cfg_wait_sel = 2'b11;
  logic cfg_float_n = 1'b1, wait_pin_en = 1'b0, wclk_en = 1'b0, wait_n = 1'b1;
  logic ale, rd_n, wr_n, bus_drive, wclk, done;

  int n_chk = 0, n_err = 0, cyc = 0;

  ext_bus_waitctl u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_region(req_region), .req_write(req_write),
    .req_cfg(req_cfg), .cfg_float_n(cfg_float_n), .cfg_wait_sel(cfg_wait_sel),
    .wait_pin_en(wait_pin_en), .wclk_en(wclk_en), .wait_n(wait_n),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .bus_drive(bus_drive), .wclk(wclk), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 address, 2 strobe, 3 done, 4 dead time
  int  ph = 0, rem = 0;
  bit  m_wr = 0, m_flt = 0, m_wclk = 0;
  logic wq[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; rem = 0; m_wr = 0; m_flt = 0; m_wclk = 0;
      wq = {1'b1, 1'b1};
    end else begin
      bit ws, ext;
      ws = wait_pin_en && !wq[0];
      void'(wq.pop_front());
      wq.push_back(wait_n);
      m_wclk = wclk_en ? !m_wclk : 1'b0;
      case (ph)
        0: if (req) begin
             ph = 1; m_wr = req_write;
             ext = !cfg_float_n || req_cfg;
             if (req_region != 2'b01) rem = 0;
             else if (ext) rem = cfg_wait_sel[1] ? 1 : 3;
             else rem = 3 - int'(cfg_wait_sel);
             m_flt = ext && !req_write;
           end
        1: ph = 2;
        2: if (!ws) begin if (rem == 0) ph = 3; else rem--; end
        3: ph = m_flt ? 4 : 0;
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(ale == (ph == 1), "R2 ale", ale, ph == 1);
    chk(rd_n == !(ph == 2 && !m_wr), "R12 rd_n", rd_n, !(ph == 2 && !m_wr));
    chk(wr_n == !(ph == 2 && m_wr), "R12 wr_n", wr_n, !(ph == 2 && m_wr));
    chk(bus_drive == (ph == 1 || (ph == 2 && m_wr)), "R11 bus_drive", bus_drive, ph == 1 || (ph == 2 && m_wr));
    chk(done == (ph == 3), "R10 done", done, ph == 3);
    chk(wclk == m_wclk, "R9 wclk", wclk, m_wclk);
    if (ph == 4) chk(!bus_drive && !ale, "R7 dead time quiet", bus_drive, 0);
  end

  task automatic run(input logic [1:0] rg, input bit wr, input bit cf, input int lw,
                     input int exp_len, input int exp_gap, input string tag);
    int len = 0, gap = 0, wl = lw;
    @(negedge clk);
    req = 1; req_region = rg; req_write = wr; req_cfg = cf;
    if (wl > 0) wait_n = 0;
    while (!ale) begin
      @(negedge clk);
      if (wl > 0) begin wl--; if (wl == 0) wait_n = 1; end
    end
    req = 0;
    @(negedge clk);
    if (wl > 0) begin wl--; if (wl == 0) wait_n = 1; end
    while (!done) begin
      if (!rd_n || !wr_n) len++;
      @(negedge clk);
      if (wl > 0) begin wl--; if (wl == 0) wait_n = 1; end
    end
    wait_n = 1;
    chk(len == exp_len, {tag, " strobe length"}, len, exp_len);
    req = 1;
    while (!ale) begin @(negedge clk); gap++; end
    req = 0;
    chk(gap == exp_gap, {tag, " done-to-ale gap"}, gap, exp_gap);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ale && rd_n && wr_n && !bus_drive && !wclk && !done, "R1 reset outputs", {ale, rd_n, wr_n, bus_drive, wclk, done}, 6'b011000);
    rst_n = 1;
    @(negedge clk);
    chk(!ale && rd_n && wr_n && !bus_drive && !wclk && !done, "R1 after reset", {ale, rd_n, wr_n, bus_drive, wclk, done}, 6'b011000);

    cfg_float_n = 1;
    cfg_wait_sel = 2'b00; run(2'b01, 0, 0, 0, 4, 2, "R3 sel00");
    cfg_wait_sel = 2'b01; run(2'b01, 0, 0, 0, 3, 2, "R3 sel01");
    cfg_wait_sel = 2'b10; run(2'b01, 1, 0, 0, 2, 2, "R3 sel10 write");
    cfg_wait_sel = 2'b11; run(2'b01, 0, 0, 0, 1, 2, "R3 sel11");

    cfg_float_n = 0;
    cfg_wait_sel = 2'b11; run(2'b01, 0, 0, 0, 2, 3, "R4 R7 sel11 read");
    cfg_wait_sel = 2'b10; run(2'b01, 0, 0, 0, 2, 3, "R4 sel10");
    cfg_wait_sel = 2'b01; run(2'b01, 0, 0, 0, 4, 3, "R4 sel01");
    cfg_wait_sel = 2'b00; run(2'b01, 0, 0, 0, 4, 3, "R4 sel00");
    cfg_wait_sel = 2'b00; run(2'b01, 1, 0, 0, 4, 2, "R7 write no dead time");

    run(2'b00, 0, 0, 0, 1, 3, "R5 region00");
    cfg_float_n = 1;
    run(2'b10, 0, 0, 0, 1, 2, "R5 region10");
    run(2'b11, 1, 0, 0, 1, 2, "R5 region11");

    cfg_wait_sel = 2'b11; run(2'b01, 0, 1, 0, 2, 3, "R6 cfg fetch sel11");
    cfg_wait_sel = 2'b01; run(2'b01, 0, 1, 0, 4, 3, "R6 cfg fetch sel01");

    wclk_en = 1;
    wait_pin_en = 1;
    run(2'b00, 0, 0, 3, 4, 2, "R8 wait held 3");
    cfg_wait_sel = 2'b10; run(2'b01, 1, 0, 2, 4, 2, "R8 wait after config waits");
    wait_pin_en = 0;
    run(2'b00, 0, 0, 3, 1, 2, "R8 pin disabled");

    @(negedge clk);
    begin
      logic w0;
      w0 = wclk;
      @(negedge clk);
      chk(wclk != w0, "R9 wclk toggles", wclk, !w0);
    end
    wclk_en = 0;
    repeat (2) @(negedge clk);
    chk(wclk == 0, "R9 wclk off", wclk, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule